// File: doc/BRIEF.md
# Per-PC Stride Prefetch Engine

This block watches the load accesses of a core. Each access carries the program counter of the load and the data address it touches. A small direct-mapped table, indexed by PC bits, remembers for every load its last address, the step between its last two addresses and a saturating confidence count. When a load keeps stepping by the same non-zero distance, the count rises. Once it passes a threshold, the block sends prefetch addresses ahead of the current access.

For a trusted stride S and depth N, the block offers the addresses A+S, A+2S, up to A+N·S one at a time on a valid/ready output. A is the address of the triggering access. Targets that leave the page of the triggering access are dropped. A fresh trigger discards whatever the previous one had left unsent. A parameter chooses how a broken stride erodes confidence: a step down by one, or a reset to zero.

Top module: `stride_prefetch_top`

## Requirements
- R1: After reset `pf_valid` is low and every table entry is empty, so the first access of any PC counts as a miss.
- R2: An access whose PC does not match the valid entry at its index is a miss. It writes the entry with tag = PC, last address = access address, stride = 0, count = 0, and it does not change the prefetch output stream.
- R3: On a hit the new stride is the access address minus the stored last address, modulo 2^ADDR_W. If it equals the stored stride, the count goes up by one. Otherwise the stored stride becomes the new stride and the count drops by one with a floor of zero, or drops to zero when MIS_POLICY is MIS_CLEAR. The default is the step-down policy. The last address is always replaced by the access address.
- R4: The count saturates at 2^CNT_W−1 and never wraps to zero.
- R5: An access triggers prefetching only if it hits, its stride matches, the stride is non-zero and the updated count is strictly greater than THRESH.
- R6: In the cycle after a trigger at address A with stride S, `pf_addr` shows A+S. Each accepted transfer (`pf_valid` and `pf_ready` high at a clock edge) advances the target to the next multiple, up to A+DEPTH·S. After the last one is accepted, `pf_valid` falls.
- R7: While `pf_valid` is high and `pf_ready` is low, and no new trigger arrives, `pf_valid` stays high and `pf_addr` holds its value.
- R8: A target whose address bits above bit PAGE_W−1 differ from those of the triggering access is never offered, and no target after it is offered either.
- R9: A new trigger replaces any unsent targets of the previous one. This holds even at an edge where the previous target is being accepted. The next cycle shows the new A+S.
- R10: A stride of zero never triggers prefetching, whatever the count.
- R11: The table index is acc_pc[PC_LSB+IDX_W−1:PC_LSB], and the tag is the full PC. A PC that shares an index with another evicts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A load access is presented this cycle |
| acc_pc | input | PC_W | Program counter of the load |
| acc_addr | input | ADDR_W | Data address of the load |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | The consumer accepts the offered address |
| pf_addr | output | ADDR_W | Prefetch target address |

## Verification
The hardest state to reach from the ports is a saturated count that is then broken by exactly one mismatched stride. The next access is the only point where a wrapping counter and a saturating one behave differently. The stimulus trains one PC for exactly seven accesses so the two paths diverge, then breaks the stride once and resumes it. The same kind of exact-length training places a trigger just below a page boundary and, with the consumer stalled, places a second trigger on top of unsent targets. A long random phase over a few PCs, some of which alias to the same index, runs with random backpressure against a behavioural queue model.

// File: rtl/spf_pkg.sv
package spf_pkg;

   // How confidence reacts when a load breaks its stride
   typedef enum logic {
      MIS_DECR  = 1'b0,
      MIS_CLEAR = 1'b1
   } mis_policy_e;

endpackage

// File: rtl/spf_conf.sv
module spf_conf #(
   parameter int                  CNT_W  = 2,
   parameter spf_pkg::mis_policy_e POLICY = spf_pkg::MIS_DECR
) (
   input  logic [CNT_W-1:0] cur_cnt,
   input  logic             same_stride,
   output logic [CNT_W-1:0] nxt_cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] up_cnt;
   logic [CNT_W-1:0] down_cnt;

   // saturating increment (R4)
   assign up_cnt = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + 1'b1;

   generate
      if (POLICY == spf_pkg::MIS_CLEAR) begin : g_clear
         assign down_cnt = '0;
      end else begin : g_decr
         assign down_cnt = (cur_cnt == '0) ? '0 : cur_cnt - 1'b1;
      end
   endgenerate

   assign nxt_cnt = same_stride ? up_cnt : down_cnt;

endmodule

// File: rtl/spf_table.sv
module spf_table #(
   parameter int                  PC_W   = 32,
   parameter int                  ADDR_W = 32,
   parameter int                  IDX_W  = 4,
   parameter int                  PC_LSB = 2,
   parameter int                  CNT_W  = 2,
   parameter int                  THRESH = 1,
   parameter spf_pkg::mis_policy_e POLICY = spf_pkg::MIS_DECR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [PC_W-1:0]   acc_pc,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              trig,
   output logic [ADDR_W-1:0] trig_base,
   output logic [ADDR_W-1:0] trig_stride
);

   localparam int               ENTRIES = 1 << IDX_W;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] THR_C   = CNT_W'(THRESH);

   logic              ent_vld    [ENTRIES];
   logic [PC_W-1:0]   ent_tag    [ENTRIES];
   logic [ADDR_W-1:0] ent_last   [ENTRIES];
   logic [ADDR_W-1:0] ent_stride [ENTRIES];
   logic [CNT_W-1:0]  ent_cnt    [ENTRIES];

   logic [IDX_W-1:0]  idx;
   logic              rd_vld;
   logic [PC_W-1:0]   rd_tag;
   logic [ADDR_W-1:0] rd_last;
   logic [ADDR_W-1:0] rd_stride;
   logic [CNT_W-1:0]  rd_cnt;
   logic              hit;
   logic [ADDR_W-1:0] new_stride;
   logic              same;
   logic [CNT_W-1:0]  nxt_cnt;
   logic [ADDR_W-1:0] wr_stride;
   logic [CNT_W-1:0]  wr_cnt;

   assign idx       = acc_pc[PC_LSB +: IDX_W];
   assign rd_vld    = ent_vld[idx];
   assign rd_tag    = ent_tag[idx];
   assign rd_last   = ent_last[idx];
   assign rd_stride = ent_stride[idx];
   assign rd_cnt    = ent_cnt[idx];

   assign hit        = acc_valid && rd_vld && (rd_tag == acc_pc);
   assign new_stride = acc_addr - rd_last;
   assign same       = (new_stride == rd_stride);

   spf_conf #(
      .CNT_W  (CNT_W),
      .POLICY (POLICY)
   ) u_conf (
      .cur_cnt     (rd_cnt),
      .same_stride (same),
      .nxt_cnt     (nxt_cnt)
   );

   // a miss allocates with zero stride and zero confidence
   assign wr_stride = hit ? new_stride : '0;
   assign wr_cnt    = hit ? nxt_cnt    : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            ent_vld[e]    <= 1'b0;
            ent_tag[e]    <= '0;
            ent_last[e]   <= '0;
            ent_stride[e] <= '0;
            ent_cnt[e]    <= '0;
         end
      end else if (acc_valid) begin
         ent_vld[idx]    <= 1'b1;
         ent_tag[idx]    <= acc_pc;
         ent_last[idx]   <= acc_addr;
         ent_stride[idx] <= wr_stride;
         ent_cnt[idx]    <= wr_cnt;
      end
   end

   assign trig        = hit && same && (new_stride != '0) && (nxt_cnt > THR_C);
   assign trig_base   = acc_addr;
   assign trig_stride = new_stride;

   // R2: a miss leaves a clean entry behind
   p_miss_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !hit) |=> (ent_cnt[$past(idx)] == '0) && (ent_stride[$past(idx)] == '0));

   // R4: a saturated count stays saturated on a repeated stride
   p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && same && rd_cnt == CNT_MAX) |=> (ent_cnt[$past(idx)] == CNT_MAX));

   // R5: a trigger needs a stored count already at the threshold
   p_trig_conf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> (rd_vld && rd_cnt >= THR_C));

endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 3,
   parameter int PAGE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_base,
   input  logic [ADDR_W-1:0] load_stride,
   input  logic              pf_ready,
   output logic              pf_valid,
   output logic [ADDR_W-1:0] pf_addr
);

   localparam int               STEP_W = $clog2(DEPTH + 1);
   localparam logic [STEP_W-1:0] LAST  = STEP_W'(DEPTH);

   logic              eng_active;
   logic [ADDR_W-1:0] eng_base;
   logic [ADDR_W-1:0] eng_stride;
   logic [STEP_W-1:0] eng_step;
   logic [ADDR_W-1:0] target;
   logic              in_page;

   assign target  = eng_base + eng_stride * ADDR_W'(eng_step);
   assign in_page = (target[ADDR_W-1:PAGE_W] == eng_base[ADDR_W-1:PAGE_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_active <= 1'b0;
         eng_base   <= '0;
         eng_stride <= '0;
         eng_step   <= '0;
      end else if (load) begin
         eng_active <= 1'b1;
         eng_base   <= load_base;
         eng_stride <= load_stride;
         eng_step   <= STEP_W'(1);
      end else if (eng_active) begin
         if (!in_page) begin
            eng_active <= 1'b0;
         end else if (pf_ready) begin
            if (eng_step == LAST) eng_active <= 1'b0;
            else                  eng_step   <= eng_step + 1'b1;
         end
      end
   end

   assign pf_valid = eng_active && in_page;
   assign pf_addr  = target;

   // R7: a stalled offer is held
   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready && !load) |=> (pf_valid && $stable(pf_addr)));

   // R6: accepted offer moves one stride on
   p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && pf_ready && !load && eng_step != LAST) |=>
         (pf_addr == $past(pf_addr) + eng_stride));

   // R6: step count stays inside the depth window
   p_step_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      eng_active |-> (eng_step >= STEP_W'(1) && eng_step <= LAST));

endmodule

// File: rtl/stride_prefetch_top.sv
module stride_prefetch_top #(
   parameter int                  PC_W       = 32,
   parameter int                  ADDR_W     = 32,
   parameter int                  IDX_W      = 4,
   parameter int                  PC_LSB     = 2,
   parameter int                  CNT_W      = 2,
   parameter int                  THRESH     = 1,
   parameter int                  DEPTH      = 3,
   parameter int                  PAGE_W     = 12,
   parameter spf_pkg::mis_policy_e MIS_POLICY = spf_pkg::MIS_DECR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [PC_W-1:0]   acc_pc,
   input  logic [ADDR_W-1:0] acc_addr,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr
);

   localparam int CNT_TOP = (1 << CNT_W) - 1;

   generate
      if (THRESH < 0 || THRESH >= CNT_TOP) begin : g_bad_thresh
         $error("THRESH must lie below the saturated count");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("DEPTH must be at least one");
      end
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("PAGE_W must be inside the address");
      end
      if (PC_LSB + IDX_W > PC_W) begin : g_bad_idx
         $error("index field exceeds the PC");
      end
   endgenerate

   logic              trig;
   logic [ADDR_W-1:0] trig_base;
   logic [ADDR_W-1:0] trig_stride;

   spf_table #(
      .PC_W   (PC_W),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .PC_LSB (PC_LSB),
      .CNT_W  (CNT_W),
      .THRESH (THRESH),
      .POLICY (MIS_POLICY)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid   (acc_valid),
      .acc_pc      (acc_pc),
      .acc_addr    (acc_addr),
      .trig        (trig),
      .trig_base   (trig_base),
      .trig_stride (trig_stride)
   );

   spf_issue #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH),
      .PAGE_W (PAGE_W)
   ) u_issue (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (trig),
      .load_base   (trig_base),
      .load_stride (trig_stride),
      .pf_ready    (pf_ready),
      .pf_valid    (pf_valid),
      .pf_addr     (pf_addr)
   );

   // R6/R9: the cycle after any trigger shows its first target
   p_first_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (pf_addr == $past(trig_base) + $past(trig_stride)));

   // R10: zero stride never reaches the engine
   p_zero_stride_r10: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> (trig_stride != '0));

endmodule

// File: tb/stride_prefetch_top_tb_top.sv
module stride_prefetch_top_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_pc = '0;
   logic [31:0] acc_addr = '0;
   logic        pf_valid;
   logic        pf_ready = 1'b1;
   logic [31:0] pf_addr;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   stride_prefetch_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_pc    (acc_pc),
      .acc_addr  (acc_addr),
      .pf_valid  (pf_valid),
      .pf_ready  (pf_ready),
      .pf_addr   (pf_addr)
   );

   // ---------------- behavioural reference ----------------
   bit          m_vld    [16];
   logic [31:0] m_tag    [16];
   logic [31:0] m_last   [16];
   logic [31:0] m_stride [16];
   int          m_cnt    [16];
   logic [31:0] m_q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) begin
            m_vld[i] = 0; m_cnt[i] = 0; m_stride[i] = '0; m_last[i] = '0; m_tag[i] = '0;
         end
         m_q.delete();
      end else begin
         if (m_q.size() > 0 && pf_ready) void'(m_q.pop_front());
         if (acc_valid) begin
            int          ix;
            logic [31:0] ns;
            ix = int'(acc_pc[5:2]);
            if (m_vld[ix] && m_tag[ix] == acc_pc) begin
               ns = acc_addr - m_last[ix];
               if (ns == m_stride[ix]) begin
                  if (m_cnt[ix] < 3) m_cnt[ix]++;
                  if (ns != 0 && m_cnt[ix] > 1) begin
                     m_q.delete();
                     for (int k = 1; k <= 3; k++) begin
                        logic [31:0] t;
                        t = acc_addr + ns * k;
                        if (t[31:12] != acc_addr[31:12]) break;
                        m_q.push_back(t);
                     end
                  end
               end else begin
                  if (m_cnt[ix] > 0) m_cnt[ix]--;
                  m_stride[ix] = ns;
               end
            end else begin
               m_vld[ix] = 1; m_tag[ix] = acc_pc; m_stride[ix] = '0; m_cnt[ix] = 0;
            end
            m_last[ix] = acc_addr;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit exp_v;
         exp_v = (m_q.size() > 0);
         checks++;
         if (pf_valid !== exp_v || (exp_v && pf_addr !== m_q[0])) begin
            errors++;
            $display("FAIL %s model: valid=%0b addr=%h expected valid=%0b addr=%h",
                     cur_req, pf_valid, pf_addr, exp_v, exp_v ? m_q[0] : 32'h0);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s directed: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [31:0] pc, input logic [31:0] addr);
      acc_valid = 1'b1; acc_pc = pc; acc_addr = addr;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      done = 1;
      summary();
   end

   logic [31:0] rnd_addr [6];
   logic [31:0] rnd_step [6];

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: nothing offered out of reset
      chk("R1", {31'b0, pf_valid}, 32'h0);
      idle(2);

      // R6: basic run, stride 0x40, targets in order
      cur_req = "R6";
      acc(32'h100, 32'h1000); acc(32'h100, 32'h1040); acc(32'h100, 32'h1080);
      chk("R5", {31'b0, pf_valid}, 32'h0);
      acc(32'h100, 32'h10C0);
      chk("R6", pf_addr, 32'h1100);
      @(negedge clk); chk("R6", pf_addr, 32'h1140);
      @(negedge clk); chk("R6", pf_addr, 32'h1180);
      @(negedge clk); chk("R6", {31'b0, pf_valid}, 32'h0);
      idle(2);

      // R8: page edge truncates, negative stride fully filtered
      cur_req = "R8";
      acc(32'h104, 32'h3A00); acc(32'h104, 32'h3B00); acc(32'h104, 32'h3C00); acc(32'h104, 32'h3D00);
      chk("R8", pf_addr, 32'h3E00);
      @(negedge clk); chk("R8", pf_addr, 32'h3F00);
      @(negedge clk); chk("R8", {31'b0, pf_valid}, 32'h0);
      acc(32'h108, 32'h5300); acc(32'h108, 32'h5200); acc(32'h108, 32'h5100); acc(32'h108, 32'h5000);
      chk("R8", {31'b0, pf_valid}, 32'h0);
      idle(2);

      // R10: repeated identical address never prefetches
      cur_req = "R10";
      for (int i = 0; i < 6; i++) acc(32'h10C, 32'h6000);
      chk("R10", {31'b0, pf_valid}, 32'h0);

      // R11 / R2: aliasing PC evicts; returning PC misses
      cur_req = "R11";
      acc(32'h400, 32'h8000); acc(32'h400, 32'h8020); acc(32'h400, 32'h8040);
      acc(32'h440, 32'h9000);
      acc(32'h400, 32'h8060);
      chk("R11", {31'b0, pf_valid}, 32'h0);
      acc(32'h400, 32'h8080);
      chk("R2", {31'b0, pf_valid}, 32'h0);
      idle(2);

      // R7 / R9: stall holds, new trigger replaces remainder
      cur_req = "R7";
      pf_ready = 1'b0;
      acc(32'h800, 32'hA000); acc(32'h800, 32'hA080); acc(32'h800, 32'hA100); acc(32'h800, 32'hA180);
      chk("R7", pf_addr, 32'hA200);
      idle(3);
      chk("R7", pf_addr, 32'hA200);
      chk("R7", {31'b0, pf_valid}, 32'h1);
      cur_req = "R9";
      acc(32'h800, 32'hA200);
      chk("R9", pf_addr, 32'hA280);
      pf_ready = 1'b1;
      acc(32'h800, 32'hA280);
      chk("R9", pf_addr, 32'hA300);
      idle(5);

      // R4: seven accesses then one break, then resume
      cur_req = "R4";
      for (int i = 0; i < 7; i++) acc(32'h900, 32'hB000 + 32'h10 * i);
      idle(4);
      acc(32'h900, 32'hB080);
      chk("R4", {31'b0, pf_valid}, 32'h0);
      acc(32'h900, 32'hB0A0);
      chk("R4", pf_addr, 32'hB0C0);
      idle(4);

      // R3: step-down keeps enough confidence to re-trigger
      cur_req = "R3";
      acc(32'hA00, 32'h7000); acc(32'hA00, 32'h7040); acc(32'hA00, 32'h7080);
      acc(32'hA00, 32'h70C0); acc(32'hA00, 32'h7100);
      idle(4);
      acc(32'hA00, 32'h7180);
      chk("R3", {31'b0, pf_valid}, 32'h0);
      acc(32'hA00, 32'h7200);
      chk("R3", pf_addr, 32'h7280);
      idle(4);

      // random mix with backpressure, compared against the model
      cur_req = "R9";
      for (int p = 0; p < 6; p++) begin
         rnd_addr[p] = 32'h0001_0000 * (p + 1);
         rnd_step[p] = 32'h40;
      end
      for (int i = 0; i < 3000; i++) begin
         int p;
         logic [31:0] pc;
         p = int'($urandom_range(0, 5));
         pc = (p == 5) ? 32'h1040 : 32'h1000 + 32'(p) * 4;
         pf_ready = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 9) == 0) rnd_step[p] = 32'h20 * $urandom_range(0, 4) - 32'h40;
         if ($urandom_range(0, 1) == 1) begin
            rnd_addr[p] = rnd_addr[p] + rnd_step[p];
            acc(pc, rnd_addr[p]);
         end else begin
            @(negedge clk);
         end
      end
      pf_ready = 1'b1;
      idle(6);
      chk("R6", {31'b0, pf_valid}, 32'h0);

      done = 1;
      summary();
   end

endmodule